// File: doc/BRIEF.md
# Segment LCD Frame Sequencer

This block produces the common (COM) and segment drive pattern for a multiplexed segment LCD using digital correlation. A programmable divider cuts the input clock into quarter ticks. Four quarters form one sub-frame, and each sub-frame belongs to one active COM line. The COM being addressed carries the current phase level, while every other active COM carries the inverse. Each segment line carries the phase level XOR'd with its stored bit for that COM. Over one full frame the phase inverts, so no line sees a net DC level.

Two frame orderings are offered. In the single-pass ordering, each COM's sub-frame is split into a positive half and a negative half. In the double-pass ordering, every COM is addressed once with a positive sub-frame and then once more with a negative sub-frame. An optional gap, counted in clock cycles, may follow each frame; during the gap every line rests low.

The enable passes through a two-stage synchronizer before it starts the sequencer. A second two-stage synchronizer returns the synchronized copy as a status bit. Configuration is changed only while that status bit reads 0. Segment bits are held in four banks. Each bank stores one nibble per segment pin, covering four consecutive COMs.

Top module: `seg_lcd_seq`

## Requirements
- R1: A quarter lasts cfg_subfr_div+1 clock cycles, and a sub-frame lasts four quarters, 4*(cfg_subfr_div+1) cycles.
- R2: The number of active COMs is cfg_com_num+2, except that the value 15 selects 16 COMs. com_idx steps from 0 up to the count minus 1, and com_out lines at or above the count stay low.
- R3: With cfg_type_b=0, each frame holds one sub-frame per COM in index order. The phase is 1 for the first two quarters and 0 for the last two. The addressed com_out line equals the phase, and every other active line equals its inverse.
- R4: With cfg_type_b=1, each frame runs every COM in order with phase 1 for whole sub-frames, and then runs every COM again with phase 0.
- R5: seg_out[i] equals the phase XOR bit 4*i+(c mod 4) of bank c/4, where c is the addressed COM index.
- R6: After the last sub-frame of a frame, all com_out and seg_out lines are low for cfg_dead_len cycles before the next frame starts. A value of 0 starts the next frame on the following cycle.
- R7: frame_start is high for exactly the first cycle of each frame, and that cycle addresses COM 0.
- R8: en_stat rises on the 4th clock edge after cfg_en rises and falls on the 4th edge after it falls. The first frame_start appears in the cycle after edge 3+cfg_subfr_div, counted from the rise of cfg_en.
- R9: From the 3rd edge after cfg_en falls, and before the first frame after enabling, all com_out and seg_out lines are low, frame_start is low and com_idx is 0.
- R10: A cycle with wr_en=1 loads wr_data into bank wr_bank. Banks reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Sequencer enable, control domain |
| cfg_subfr_div | input | DIVW | Quarter length minus 1, in cycles |
| cfg_dead_len | input | DIVW | Gap after each frame, in cycles |
| cfg_com_num | input | 4 | Active COM count minus 2 (15 means 16) |
| cfg_type_b | input | 1 | 0: split sub-frame ordering, 1: double-pass ordering |
| wr_en | input | 1 | Bank write strobe |
| wr_bank | input | 2 | Bank to write (COMs 4b..4b+3) |
| wr_data | input | 4*NSEG | Nibble per pin, lowest COM in bit 0 of the nibble |
| en_stat | output | 1 | Enable status returned through the synchronizers |
| com_out | output | 16 | COM drive levels |
| seg_out | output | NSEG | Segment drive levels |
| frame_start | output | 1 | Pulse on the first cycle of each frame |
| com_idx | output | 4 | COM index being addressed |

## Verification
The bench predicts every output on every cycle from a closed-form position inside the frame. This catches a quarter that is one cycle long or short, a gap that is off by one, or a double-pass ordering that inverts per COM instead of per pass. The COM-count code 15 and the smallest count are tested directly. A design that wrapped code 15 to 1 COM, or that drove lines beyond the count, would show wrong com_out patterns. Random bank contents at every COM position show a wrong nibble bit or bank selection on seg_out. The enable-to-first-frame latency and the status round trip are counted edge by edge, so a missing or extra synchronizer stage is reported.

// File: rtl/seg_lcd_seq.sv
module seg_lcd_seq #(
  parameter int NSEG = 8,
  parameter int DIVW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic [DIVW-1:0]    cfg_subfr_div,
  input  logic [DIVW-1:0]    cfg_dead_len,
  input  logic [3:0]         cfg_com_num,
  input  logic               cfg_type_b,
  input  logic               wr_en,
  input  logic [1:0]         wr_bank,
  input  logic [4*NSEG-1:0]  wr_data,
  output logic               en_stat,
  output logic [15:0]        com_out,
  output logic [NSEG-1:0]    seg_out,
  output logic               frame_start,
  output logic [3:0]         com_idx
);
  localparam int NCOM = 16;
  localparam int BW   = 4 * NSEG;

  logic [1:0] en_s, st_s;
  logic       en_run;
  assign en_run  = en_s[1];
  assign en_stat = st_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s <= '0;
      st_s <= '0;
    end else begin
      en_s <= {en_s[0], cfg_en};
      st_s <= {st_s[0], en_run};
    end
  end

  logic [BW-1:0] bank [4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) bank[b] <= '0;
    end else if (wr_en) begin
      bank[wr_bank] <= wr_data;
    end
  end

  logic [DIVW-1:0] div_cnt, dead_cnt;
  logic [1:0]      q;
  logic [3:0]      com;
  logic            pass, started, dead;
  logic [3:0]      last_com;
  logic            tick, frame_end, active, phase;

  assign last_com  = (cfg_com_num == 4'hF) ? 4'hF : cfg_com_num + 4'd1;
  assign tick      = en_run && !dead && (div_cnt == cfg_subfr_div);
  assign frame_end = started && (q == 2'd3) && (com == last_com) && (!cfg_type_b || pass);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0; dead_cnt <= '0; q <= '0; com <= '0;
      pass <= 1'b0; started <= 1'b0; dead <= 1'b0;
    end else if (!en_run) begin
      div_cnt <= '0; dead_cnt <= '0; q <= '0; com <= '0;
      pass <= 1'b0; started <= 1'b0; dead <= 1'b0;
    end else if (dead) begin
      if (dead_cnt == cfg_dead_len - DIVW'(1)) begin
        dead     <= 1'b0;
        dead_cnt <= '0;
      end else begin
        dead_cnt <= dead_cnt + DIVW'(1);
      end
    end else if (tick) begin
      div_cnt <= '0;
      if (!started) begin
        started <= 1'b1;
      end else if (frame_end) begin
        q    <= '0;
        com  <= '0;
        pass <= 1'b0;
        if (cfg_dead_len != '0) begin
          dead     <= 1'b1;
          dead_cnt <= '0;
        end
      end else if (q == 2'd3) begin
        q <= '0;
        if (com == last_com) begin
          com  <= '0;
          pass <= 1'b1;
        end else begin
          com <= com + 4'd1;
        end
      end else begin
        q <= q + 2'd1;
      end
    end else begin
      div_cnt <= div_cnt + DIVW'(1);
    end
  end

  assign active      = started && !dead;
  assign phase       = cfg_type_b ? ~pass : ~q[1];
  assign frame_start = active && (com == 4'd0) && (q == 2'd0) && !pass && (div_cnt == '0);
  assign com_idx     = com;

  logic [BW-1:0] sel;
  assign sel = bank[com[3:2]];

  for (genvar k = 0; k < NCOM; k++) begin : g_com
    assign com_out[k] = active && (4'(k) <= last_com) && ((com == 4'(k)) ? phase : ~phase);
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic [3:0] nib;
    assign nib        = sel[4*i +: 4];
    assign seg_out[i] = active && (phase ^ nib[com[1:0]]);
  end

  // R1
  div_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_stat |-> (div_cnt <= cfg_subfr_div));

  // R2
  com_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_stat |-> (com_idx <= last_com));

  // R6
  dead_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dead) |-> ($past(q) == 2'd3 && $past(com) == last_com));

  // R7
  fs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_run |=> (com_out == '0 && seg_out == '0 && !frame_start));
endmodule

// File: tb/seg_lcd_seq_tb_top.sv
`timescale 1ns/100ps
module seg_lcd_seq_tb_top;
  localparam int NSEG = 8;
  localparam int DIVW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_en = 1'b0, cfg_type_b = 1'b0, wr_en = 1'b0;
  logic [DIVW-1:0] cfg_subfr_div = '0, cfg_dead_len = '0;
  logic [3:0] cfg_com_num = '0;
  logic [1:0] wr_bank = '0;
  logic [4*NSEG-1:0] wr_data = '0;
  logic en_stat, frame_start;
  logic [15:0] com_out;
  logic [NSEG-1:0] seg_out;
  logic [3:0] com_idx;

  int checks = 0, errors = 0, cycles = 0;
  logic [4*NSEG-1:0] bdat [4];

  always #2.5 clk = ~clk;

  seg_lcd_seq #(.NSEG(NSEG), .DIVW(DIVW)) dut_i (
    .clk, .rst_n, .cfg_en, .cfg_subfr_div, .cfg_dead_len, .cfg_com_num,
    .cfg_type_b, .wr_en, .wr_bank, .wr_data, .en_stat, .com_out, .seg_out,
    .frame_start, .com_idx);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic predict(input int t, input int d, input int dl, input int cn, input bit tb,
                         output logic [15:0] ec, output logic [NSEG-1:0] es,
                         output logic efs, output logic [3:0] eidx, output bit in_dead);
    int ns, ql, sub, act, o, slot, c, r;
    bit ph, ps;
    ns   = (cn == 15) ? 16 : cn + 2;
    ql   = d + 1;
    sub  = 4 * ql;
    act  = (tb ? 2 : 1) * ns * sub;
    o    = t % (act + dl);
    ec = '0; es = '0; efs = 1'b0; eidx = '0; in_dead = 1'b0;
    if (o >= act) begin
      in_dead = 1'b1;
      return;
    end
    slot = o / sub;
    ps   = tb ? (slot >= ns) : 1'b0;
    c    = slot % ns;
    r    = o % sub;
    ph   = tb ? !ps : (r < 2 * ql);
    for (int k = 0; k < ns; k++) ec[k] = (k == c) ? ph : !ph;
    for (int i = 0; i < NSEG; i++) es[i] = ph ^ bdat[c / 4][4 * i + c % 4];
    efs  = (o == 0);
    eidx = 4'(c);
  endtask

  task automatic run_cfg(input int d, input int dl, input int cn, input bit tb, input int nfr);
    int n, ns, flen;
    logic [15:0] ec; logic [NSEG-1:0] es; logic efs; logic [3:0] eidx; bit dd;
    @(negedge clk);
    cfg_en = 1'b0;
    n = 0;
    while (en_stat && n < 20) begin @(negedge clk); n++; end
    cfg_subfr_div = DIVW'(d); cfg_dead_len = DIVW'(dl);
    cfg_com_num = 4'(cn); cfg_type_b = tb;
    for (int b = 0; b < 4; b++) begin
      wr_en = 1'b1; wr_bank = 2'(b); wr_data = $urandom; bdat[b] = wr_data;
      @(negedge clk);
    end
    wr_en = 1'b0;
    // R9: idle while disabled
    chk(com_out == '0 && seg_out == '0 && !frame_start, "R9", {16'(seg_out), com_out}, 0);
    cfg_en = 1'b1;
    n = 0;
    while (!frame_start && n < 100) begin
      @(negedge clk); n++;
      if (n == 3) chk(!en_stat, "R8", 32'(en_stat), 0);
      if (n == 4) chk(en_stat, "R8", 32'(en_stat), 1);
      if (!frame_start) chk(com_out == '0 && seg_out == '0, "R9", {16'(seg_out), com_out}, 0);
    end
    chk(n == 3 + d, "R8", 32'(n), 32'(3 + d));
    ns   = (cn == 15) ? 16 : cn + 2;
    flen = (tb ? 2 : 1) * ns * 4 * (d + 1) + dl;
    for (int t = 0; t < nfr * flen; t++) begin
      predict(t, d, dl, cn, tb, ec, es, efs, eidx, dd);
      if (dd) chk(com_out == ec && seg_out == es, "R6", {16'(seg_out), com_out}, {16'(es), ec});
      else if (tb) chk(com_out == ec, "R4 R2", 32'(com_out), 32'(ec));
      else chk(com_out == ec, "R3 R2", 32'(com_out), 32'(ec));
      chk(seg_out == es, "R5 R10", 32'(seg_out), 32'(es));
      chk(frame_start == efs, "R1 R7", 32'(frame_start), 32'(efs));
      chk(com_idx == eidx, "R2", 32'(com_idx), 32'(eidx));
      @(negedge clk);
    end
    cfg_en = 1'b0;
    for (int e = 1; e <= 4; e++) begin
      @(negedge clk);
      if (e >= 3) chk(com_out == '0 && seg_out == '0 && !frame_start && com_idx == 0,
                      "R9", {16'(seg_out), com_out}, 0);
      if (e == 3) chk(en_stat, "R8", 32'(en_stat), 1);
      if (e == 4) chk(!en_stat, "R8", 32'(en_stat), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int b = 0; b < 4; b++) bdat[b] = '0;
    repeat (3) @(negedge clk);
    chk(com_out == '0 && seg_out == '0 && !en_stat && !frame_start, "R9", 32'(com_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run_cfg(0, 0, 0, 1'b0, 3);
    run_cfg(1, 3, 15, 1'b1, 2);
    run_cfg(2, 0, 14, 1'b0, 2);
    run_cfg(0, 5, 1, 1'b1, 3);
    run_cfg(3, 1, 15, 1'b0, 2);
    for (int k = 0; k < 8; k++)
      run_cfg(int'($urandom % 4), int'($urandom % 5), int'($urandom % 16), 1'($urandom), 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule